// File: doc/BRIEF.md
# Overtemperature Trip Latch

This block guards a die against a runaway cooling failure. Every clock it samples a digital junction-temperature code and compares it with a trip point. The trip point is a programmable maximum rated temperature plus a fixed margin of 20 degrees. Once the block is armed, one sample at or above the trip point sets a latch. The latch drives an active-low trip pin low. It also asserts a clock-halt enable that stops the internal clocks, and a request to the regulator to remove the core supply.

The block arms only while three inputs are all high: power-good, core-supply-valid and termination-supply-valid. Each passes through a two-flop synchronizer. A programmable arming delay must then run out. Its default keeps the time from power-good to a possible trip within 10 µs at a 100 MHz clock. A latched trip is held whatever the temperature does afterwards. The only way to clear it is for one of the three enable inputs to fall. When the enables return and the die is still hot, the block re-arms and trips again.

Top module: `overtemp_trip_latch`

## Requirements
- R1: During and right after the asynchronous reset (rstN low), tripN is 1, clkHalt is 0 and supplyOffReq is 0.
- R2: The trip point is maxTemp + 20, computed without wrap-around. A temperature code equal to or above the trip point trips the latch. A code of maxTemp + 19 does not trip it.
- R3: No trip occurs until the block is armed. After powerGood, coreOk and termOk are all high, with a hot code held steady, tripN first goes low exactly ARM_CYCLES + 3 clock cycles later.
- R4: While tripped, tripN is 0, clkHalt is 1 and supplyOffReq is 1, all together. Otherwise tripN is 1 and the other two outputs are 0.
- R5: A latched trip stays asserted when the temperature code falls below the trip point.
- R6: Lowering any one of powerGood, coreOk or termOk clears a latched trip. tripN returns to 1 exactly 3 clock cycles after the drop.
- R7: After a clear, if the temperature is still at or above the trip point, the trip asserts again ARM_CYCLES + 3 cycles after all enables are high again.
- R8: While armed, a hot code applied before clock edge k gives tripN high after edge k and low after edge k+1.
- R9: When maxTemp + 20 exceeds the largest code, no temperature code trips the block.
- R10: If any enable input drops during the arming delay, the delay starts over from zero.
- R11: Lowering rstN while tripped sets tripN to 1 at once, with no clock edge.
- R12: With the default ARM_CYCLES of 990, a trip on a hot die occurs no more than 1000 cycles (10 µs at 100 MHz) after the enables rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tempCode | input | TEMP_W | Junction-temperature code from the sensor |
| maxTemp | input | TEMP_W | Programmable maximum rated temperature |
| powerGood | input | 1 | Power-good, asynchronous |
| coreOk | input | 1 | Core supply valid, asynchronous |
| termOk | input | 1 | Termination supply valid, asynchronous |
| tripN | output | 1 | Catastrophic overtemperature pin, active low |
| clkHalt | output | 1 | Enables gating off of the internal clocks |
| supplyOffReq | output | 1 | Request to remove the core supply |

## Verification
The hardest case to reach from the ports is an enable that drops part-way through the arming delay. The pulse is short, and its only visible effect is that a later trip happens some cycles after it otherwise would. The bench holds a hot code and raises all enables. It lowers termOk for a few cycles in the middle of the count, then measures the trip edge from the re-rise to the exact cycle. The exact clear and re-trip cycles are also pinned down after each of the three enables falls, so an extra or missing synchronizer stage shows up as a miscount.

// File: rtl/otl_pkg.sv
package otl_pkg;
  // Number of flops in each enable synchronizer.
  localparam int SYNC_DEPTH = 2;

  // Strobes from control to the temperature datapath.
  typedef struct packed {
    logic sampleEn;   // capture the incoming temperature code
    logic sampleClr;  // flush the held sample while unpowered
  } otlStrobe_t;
endpackage

// File: rtl/otl_datapath.sv
module otl_datapath
  import otl_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int MARGIN = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  otlStrobe_t        strobe,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [TEMP_W-1:0] maxTemp,
  output logic              hot
);
  localparam int WIDE_W = TEMP_W + 1;

  logic [TEMP_W-1:0] tempQ;
  logic [WIDE_W-1:0] threshold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempQ <= '0;
    end else if (strobe.sampleClr) begin
      tempQ <= '0;
    end else if (strobe.sampleEn) begin
      tempQ <= tempCode;
    end
  end

  // The extra bit keeps maxTemp + MARGIN from wrapping around.
  always_comb begin
    threshold = {1'b0, maxTemp} + WIDE_W'(MARGIN);
    hot       = ({1'b0, tempQ} >= threshold);
  end

  // R9: a trip point beyond the code range can never be reached.
  assert_no_wrap_hot_R9: assert property (@(posedge clk) disable iff (!rstN)
    (threshold > WIDE_W'((1 << TEMP_W) - 1)) |-> !hot);
endmodule

// File: rtl/otl_ctrl.sv
module otl_ctrl
  import otl_pkg::*;
#(
  parameter int ARM_CYCLES = 990
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       coreOk,
  input  logic       termOk,
  input  logic       hotIn,
  output otlStrobe_t strobe,
  output logic       tripActive
);
  localparam int CNT_W = $clog2(ARM_CYCLES + 1);
  localparam int NUM_EN = 3;

  logic [NUM_EN-1:0] rawEn;
  logic [NUM_EN-1:0] syncEn;
  logic              enAll;
  logic [CNT_W-1:0]  armCnt;
  logic              armed;
  logic              latchQ;

  assign rawEn = {powerGood, coreOk, termOk};

  for (genvar i = 0; i < NUM_EN; i++) begin : g_sync
    logic [SYNC_DEPTH-1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= '0;
      else       stage <= {stage[SYNC_DEPTH-2:0], rawEn[i]};
    end
    assign syncEn[i] = stage[SYNC_DEPTH-1];
  end

  assign enAll = &syncEn;
  assign armed = (armCnt == CNT_W'(ARM_CYCLES));

  // The arming delay starts over whenever an enable is missing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armCnt <= '0;
    end else if (!enAll) begin
      armCnt <= '0;
    end else if (!armed) begin
      armCnt <= armCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
    end else if (!enAll) begin
      latchQ <= 1'b0;
    end else if (armed && hotIn) begin
      latchQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.sampleEn  = enAll;
    strobe.sampleClr = !enAll;
    tripActive       = latchQ;
  end

  // R3: the latch can only rise from an armed, hot state.
  assert_set_needs_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    (latchQ && !$past(latchQ)) |-> ($past(armed) && $past(hotIn)));

  // R8: armed and hot sets the latch on the following edge.
  assert_hot_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enAll && armed && hotIn) |=> latchQ);

  // R5: with enables present the latch only holds.
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (latchQ && enAll) |=> latchQ);

  // R6: a missing enable clears the latch.
  assert_clear_on_loss_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enAll |=> !latchQ);

  // R10: the counter never passes its limit and restarts on loss.
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    armCnt <= CNT_W'(ARM_CYCLES));
  assert_cnt_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enAll |=> (armCnt == '0));
endmodule

// File: rtl/overtemp_trip_latch.sv
module overtemp_trip_latch
  import otl_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int MARGIN     = 20,
  parameter int ARM_CYCLES = 990
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [TEMP_W-1:0] maxTemp,
  input  logic              powerGood,
  input  logic              coreOk,
  input  logic              termOk,
  output logic              tripN,
  output logic              clkHalt,
  output logic              supplyOffReq
);
  otlStrobe_t strobe;
  logic       hot;
  logic       tripActive;

  otl_ctrl #(.ARM_CYCLES(ARM_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerGood  (powerGood),
    .coreOk     (coreOk),
    .termOk     (termOk),
    .hotIn      (hot),
    .strobe     (strobe),
    .tripActive (tripActive)
  );

  otl_datapath #(.TEMP_W(TEMP_W), .MARGIN(MARGIN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tempCode (tempCode),
    .maxTemp  (maxTemp),
    .hot      (hot)
  );

  assign tripN        = !tripActive;
  assign clkHalt      = tripActive;
  assign supplyOffReq = tripActive;

  // R4: halt and supply-off follow the trip pin on every edge.
  assert_outputs_agree_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkHalt == !tripN) && (supplyOffReq == !tripN));
endmodule

// File: tb/overtemp_trip_latch_test.sv
module overtemp_trip_latch_test;
  localparam int TW  = 8;
  localparam int ARM = 990;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] tempCode = '0;
  logic [TW-1:0] maxTemp = 8'd80;
  logic          powerGood = 1'b0;
  logic          coreOk = 1'b0;
  logic          termOk = 1'b0;
  logic          tripN;
  logic          clkHalt;
  logic          supplyOffReq;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  overtemp_trip_latch uut (
    .clk(clk), .rstN(rstN), .tempCode(tempCode), .maxTemp(maxTemp),
    .powerGood(powerGood), .coreOk(coreOk), .termOk(termOk),
    .tripN(tripN), .clkHalt(clkHalt), .supplyOffReq(supplyOffReq)
  );

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 200000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<200000", cycleCount);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req, input bit tripped);
    checkVal(req, "tripN", tripN, !tripped);
    checkVal(req, "clkHalt", clkHalt, tripped);
    checkVal(req, "supplyOffReq", supplyOffReq, tripped);
  endtask

  task automatic setEn(input bit v);
    powerGood = v; coreOk = v; termOk = v;
  endtask

  task automatic disarm();
    setEn(1'b0);
    step(5);
  endtask

  task automatic testReset();
    #1;
    checkState("R1", 1'b0);
    step(3);
    rstN = 1'b1;
    step(2);
    checkState("R1", 1'b0);
  endtask

  task automatic testArmDelay();
    maxTemp = 8'd80; tempCode = 8'd120;
    setEn(1'b1);
    step(ARM + 2);
    checkVal("R3", "tripN before arm done", tripN, 1);
    step(1);
    checkState("R3", 1'b1);
    checkVal("R12", "trip within 1000 cycles", (ARM + 3 <= 1000), 1);
    checkState("R4", 1'b1);
  endtask

  task automatic testHold();
    tempCode = 8'd0;
    step(20);
    checkState("R5", 1'b1);
  endtask

  task automatic testClearAndRetrip();
    tempCode = 8'd150;
    powerGood = 1'b0;
    step(2);
    checkVal("R6", "tripN 2 cycles after pg drop", tripN, 0);
    step(1);
    checkState("R6", 1'b0);
    step(3);
    powerGood = 1'b1;
    step(ARM + 2);
    checkVal("R7", "tripN before re-arm", tripN, 1);
    step(1);
    checkState("R7", 1'b1);
    coreOk = 1'b0;
    step(3);
    checkVal("R6", "tripN after coreOk drop", tripN, 1);
    coreOk = 1'b1;
    step(ARM + 3);
    checkVal("R7", "re-trip after coreOk", tripN, 0);
    termOk = 1'b0;
    step(2);
    checkVal("R6", "tripN 2 cycles after termOk drop", tripN, 0);
    step(1);
    checkVal("R6", "tripN after termOk drop", tripN, 1);
    termOk = 1'b1;
    step(5);
  endtask

  task automatic testBoundary();
    disarm();
    maxTemp = 8'd60; tempCode = 8'd79;
    setEn(1'b1);
    step(ARM + 10);
    checkVal("R2", "tripN at max+19", tripN, 1);
    tempCode = 8'd80;
    step(1);
    checkVal("R8", "tripN one edge after hot", tripN, 1);
    step(1);
    checkVal("R2", "tripN at max+20", tripN, 0);
    checkState("R8", 1'b1);
  endtask

  task automatic testNoWrap();
    disarm();
    maxTemp = 8'd250; tempCode = 8'd255;
    setEn(1'b1);
    step(ARM + 20);
    checkState("R9", 1'b0);
  endtask

  task automatic testRestart();
    disarm();
    maxTemp = 8'd80; tempCode = 8'd200;
    setEn(1'b1);
    step(500);
    termOk = 1'b0;
    step(4);
    termOk = 1'b1;
    step(ARM + 2);
    checkVal("R10", "tripN before restarted delay ends", tripN, 1);
    step(1);
    checkVal("R10", "tripN after restarted delay", tripN, 0);
  endtask

  task automatic testAsyncReset();
    checkVal("R11", "tripN tripped before reset", tripN, 0);
    @(negedge clk);
    #2;
    rstN = 1'b0;
    #1;
    checkState("R11", 1'b0);
    step(2);
    rstN = 1'b1;
  endtask

  initial begin
    testReset();
    testArmDelay();
    testHold();
    testClearAndRetrip();
    testBoundary();
    testNoWrap();
    testRestart();
    testAsyncReset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule